// File: doc/BRIEF.md
# Fractional PLL rate calculator

This block turns a requested output frequency into the settings of a fractional-N synthesiser, and turns such settings back into a frequency. For a forward request it divides the requested rate by the reference rate to get the integer multiplier. It then divides the remainder, scaled by 2^32, to get a 32-bit fraction that is rounded up. The block recomputes the rate those settings really give and looks it up in a small parameter table of oscillator bands. It also packs the fraction into the register form that a synthesiser's control words expect.

A request is latched on a one-cycle `start` pulse. The operation is chosen by `op`. Set (0) reports an error when no band contains the rate. Round (1) clamps the rate to the outer limits of the table. Readback (2, and also 3) takes a multiplier and packed fraction registers and returns the resulting rate. The two divisions run on a restoring shift-subtract divider that retires one quotient bit per cycle. A one-cycle `done` pulse marks the end of each operation, and the results are held until the next `start` is accepted.

Top module: `pll_rate_calc`

## Requirements
- R1: For op 0 (set) and op 1 (round), `lOut` equals floor(reqRate / refRate). When the remainder of that division is zero, `alphaOut` is 0 and the computed rate equals `reqRate`.
- R2: When that remainder r is nonzero, `alphaOut` equals floor(r·2^32 / refRate), plus one if that division leaves a nonzero remainder.
- R3: `rateOut` equals refRate·L + ((refRate·alpha) >> 32), computed at 64 bits, except where R8 clamps it.
- R4: With `narrowAlpha` low, `alphaLoOut` holds bits 31:0 of alpha·2^8 and `alphaHiOut` holds alpha[31:24] in its bits 7:0, with all other bits zero. With `narrowAlpha` high, `alphaLoOut` is alpha[15:0] zero-extended and `alphaHiOut` is 0.
- R5: For op 2 or op 3 (readback), L is `lIn`. With `narrowAlpha` low, alpha is {alphaHiIn[7:0], alphaLoIn[31:8]}; with it high, alpha is alphaLoIn[15:0]. Alpha is forced to 0 when `ctlIn` bit 24 is clear. `rateOut` then follows R3, `rangeErr` is 0 and `ctlOut` equals `ctlIn`.
- R6: The band is the lowest-indexed table entry with min ≤ rate ≤ max, and its 2-bit code appears on `bandCode`; `bandCode` is 0 when no entry matches. On a set that finds a band, `ctlOut` is `ctlIn` with bits 21:20 replaced by the code and bit 24 set, all other bits unchanged.
- R7: A set whose rate lies in no band raises `rangeErr` and leaves `ctlOut` equal to `ctlIn`.
- R8: A round whose rate lies in no band reports the first entry's minimum if the rate is below it, the last entry's maximum if the rate is above it, and otherwise the rate unchanged. `rangeErr` stays 0.
- R9: A set or round with `refRate` equal to 0 raises `divZero`, skips the division and still ends with `done`. `divZero` clears at the next accepted `start`.
- R10: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after an accepted `start` until `done`, and a `start` that arrives while `busy` is high has no effect on the results.
- R11: After reset, `busy`, `done`, `divZero`, `rangeErr`, `lOut`, `alphaOut` and `rateOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| op | input | 2 | 0 set, 1 round, 2 or 3 readback |
| narrowAlpha | input | 1 | Selects the 16-bit fraction register form |
| refRate | input | 32 | Reference frequency |
| reqRate | input | 32 | Requested output frequency (set, round) |
| lIn | input | 32 | Integer multiplier for readback |
| alphaLoIn | input | 32 | Low fraction register word for readback |
| alphaHiIn | input | 32 | Upper fraction register word for readback |
| ctlIn | input | 32 | Current user control word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| divZero | output | 1 | Reference rate was zero |
| rangeErr | output | 1 | Set request matched no band |
| bandCode | output | 2 | Code of the matching band, 0 if none |
| lOut | output | 32 | Integer multiplier |
| alphaOut | output | 32 | 32-bit fraction |
| alphaLoOut | output | 32 | Packed low fraction word |
| alphaHiOut | output | 32 | Packed upper fraction word |
| ctlOut | output | 32 | Updated user control word |
| rateOut | output | 64 | Resulting or clamped rate |

## Verification
The hardest case to reach is the round-up of the fraction when the carry makes the recomputed rate land exactly on a band edge that two table entries share. Reaching it needs a reference and a request whose remainder divides unevenly. The stimulus uses a 19.2 MHz reference with a 1 GHz request, which ends on the shared edge and must pick the first band. It also uses a reference of 7 with a request three above 1 GHz, which is pushed into the second band. A second awkward case is a new `start` arriving in the middle of the 64-cycle division. The bench raises it part way through a run and shows that the original request's results come out unchanged.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int RATE_W      = 32;
  localparam int FRAC_W      = 32;
  localparam int WORD_W      = 32;
  localparam int DIV_W       = RATE_W + FRAC_W;
  localparam int RES_W       = 2 * RATE_W;
  localparam int CNT_W       = $clog2(DIV_W);
  localparam int CODE_W      = 2;
  localparam int CODE_LSB    = 20;
  localparam int FRAC_EN_BIT = 24;
  localparam int PACK_SHIFT  = 8;
  localparam int NARROW_W    = 16;

  typedef enum logic [1:0] {
    OP_SET     = 2'd0,
    OP_ROUND   = 2'd1,
    OP_RECALC  = 2'd2,
    OP_RECALC2 = 2'd3
  } op_e;

  typedef struct packed {
    logic latch;
    logic step;
    logic takeInt;
    logic loadFrac;
    logic takeFrac;
    logic calc;
  } strobe_t;
endpackage

// File: rtl/pll_calc_band.sv
module pll_calc_band
  import pll_calc_pkg::*;
#(
  parameter int NUM_BANDS = 3,
  parameter logic [NUM_BANDS-1:0][RATE_W-1:0] BAND_MIN = '0,
  parameter logic [NUM_BANDS-1:0][RATE_W-1:0] BAND_MAX = '0,
  parameter logic [NUM_BANDS-1:0][CODE_W-1:0] BAND_CODE = '0
) (
  input  logic [RES_W-1:0]  rate,
  output logic              hit,
  output logic [CODE_W-1:0] code,
  output logic [RES_W-1:0]  clamped,
  output logic [RES_W-1:0]  limLo,
  output logic [RES_W-1:0]  limHi
);
  assign limLo = RES_W'(BAND_MIN[0]);
  assign limHi = RES_W'(BAND_MAX[NUM_BANDS-1]);

  // Walk from the top so the lowest matching index wins.
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (rate >= RES_W'(BAND_MIN[i]) && rate <= RES_W'(BAND_MAX[i])) begin
        hit  = 1'b1;
        code = BAND_CODE[i];
      end
    end
  end

  always_comb begin
    if (rate < limLo)      clamped = limLo;
    else if (rate > limHi) clamped = limHi;
    else                   clamped = rate;
  end
endmodule

// File: rtl/pll_calc_ctrl.sv
module pll_calc_ctrl
  import pll_calc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    isRecalc,
  input  logic    refZero,
  input  logic    remZero,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {
    S_IDLE, S_DIV_INT, S_MID, S_DIV_FRAC, S_FIX, S_CALC, S_FIN
  } state_e;

  state_e state, nxt;
  logic [CNT_W-1:0] cnt;
  logic lastStep;

  assign lastStep = (cnt == CNT_W'(DIV_W - 1));
  assign busy = (state != S_IDLE) && (state != S_FIN);
  assign done = (state == S_FIN);

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      S_IDLE: if (start) begin
        strb.latch = 1'b1;
        if (isRecalc)     nxt = S_CALC;
        else if (refZero) nxt = S_FIN;
        else              nxt = S_DIV_INT;
      end
      S_DIV_INT: begin
        strb.step = 1'b1;
        if (lastStep) nxt = S_MID;
      end
      S_MID: begin
        strb.takeInt = 1'b1;
        if (remZero) nxt = S_CALC;
        else begin
          strb.loadFrac = 1'b1;
          nxt = S_DIV_FRAC;
        end
      end
      S_DIV_FRAC: begin
        strb.step = 1'b1;
        if (lastStep) nxt = S_FIX;
      end
      S_FIX: begin
        strb.takeFrac = 1'b1;
        nxt = S_CALC;
      end
      S_CALC: begin
        strb.calc = 1'b1;
        nxt = S_FIN;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == S_DIV_INT || state == S_DIV_FRAC)
        cnt <= lastStep ? '0 : cnt + CNT_W'(1);
      else
        cnt <= '0;
    end
  end

  // R10: completion lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: busy has dropped by the cycle done shows
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R10: work begins only on a start request
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/pll_calc_dp.sv
module pll_calc_dp
  import pll_calc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        op,
  input  logic              narrowIn,
  input  logic [RATE_W-1:0] refIn,
  input  logic [RATE_W-1:0] reqIn,
  input  logic [RATE_W-1:0] lIn,
  input  logic [WORD_W-1:0] alphaLoIn,
  input  logic [WORD_W-1:0] alphaHiIn,
  input  logic [WORD_W-1:0] ctlIn,
  input  logic              bandHit,
  input  logic [CODE_W-1:0] bandCode,
  input  logic [RES_W-1:0]  clampedRate,
  input  logic [RES_W-1:0]  limLo,
  input  logic [RES_W-1:0]  limHi,
  output logic              remZero,
  output logic [RES_W-1:0]  rateCalc,
  output logic              divZero,
  output logic              rangeErr,
  output logic [CODE_W-1:0] codeOut,
  output logic [RATE_W-1:0] lOut,
  output logic [FRAC_W-1:0] alphaOut,
  output logic [WORD_W-1:0] alphaLoOut,
  output logic [WORD_W-1:0] alphaHiOut,
  output logic [WORD_W-1:0] ctlOut,
  output logic [RES_W-1:0]  rateOut
);
  op_e               opReg;
  logic              narrowReg;
  logic [RATE_W-1:0] refReg;
  logic [WORD_W-1:0] ctlReg;
  logic [RATE_W-1:0] remReg;
  logic [DIV_W-1:0]  dvdReg;
  logic [RATE_W:0]   remShift;
  logic              fits;
  logic [RATE_W-1:0] remNext;
  logic [FRAC_W-1:0] alphaRead;
  logic [WORD_W-1:0] ctlNew;
  logic [RES_W-1:0]  prodFrac;
  logic [FRAC_W+PACK_SHIFT-1:0] alphaWide;
  logic              inRecalc;

  assign inRecalc = op[1];

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  always_comb begin
    remShift = {remReg, dvdReg[DIV_W-1]};
    fits     = remShift >= {1'b0, refReg};
    remNext  = fits ? RATE_W'(remShift - {1'b0, refReg}) : remShift[RATE_W-1:0];
  end

  // Readback of packed fraction registers.
  always_comb begin
    if (narrowIn) alphaRead = FRAC_W'(alphaLoIn[NARROW_W-1:0]);
    else          alphaRead = FRAC_W'({alphaHiIn, alphaLoIn} >> PACK_SHIFT);
    if (!ctlIn[FRAC_EN_BIT]) alphaRead = '0;
  end

  always_comb begin
    ctlNew = ctlReg;
    ctlNew[CODE_LSB +: CODE_W] = bandCode;
    ctlNew[FRAC_EN_BIT] = 1'b1;
  end

  assign prodFrac = RES_W'(refReg) * RES_W'(alphaOut);
  assign rateCalc = RES_W'(refReg) * RES_W'(lOut) + (prodFrac >> FRAC_W);
  assign remZero  = (remReg == '0);

  // Register-form packing of the fraction.
  assign alphaWide = {alphaOut, PACK_SHIFT'(0)};
  always_comb begin
    if (narrowReg) begin
      alphaLoOut = WORD_W'(alphaOut[NARROW_W-1:0]);
      alphaHiOut = '0;
    end else begin
      alphaLoOut = alphaWide[WORD_W-1:0];
      alphaHiOut = WORD_W'(alphaWide >> WORD_W);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= OP_SET; narrowReg <= 1'b0; refReg <= '0; ctlReg <= '0;
      remReg <= '0; dvdReg <= '0; lOut <= '0; alphaOut <= '0;
      rateOut <= '0; codeOut <= '0; rangeErr <= 1'b0; divZero <= 1'b0;
      ctlOut <= '0;
    end else begin
      if (strb.latch) begin
        opReg     <= op_e'(op);
        narrowReg <= narrowIn;
        refReg    <= refIn;
        ctlReg    <= ctlIn;
        remReg    <= '0;
        dvdReg    <= {FRAC_W'(0), reqIn};
        lOut      <= inRecalc ? lIn : '0;
        alphaOut  <= inRecalc ? alphaRead : '0;
        rateOut   <= '0;
        codeOut   <= '0;
        rangeErr  <= 1'b0;
        divZero   <= !inRecalc && (refIn == '0);
        ctlOut    <= ctlIn;
      end
      if (strb.step) begin
        remReg <= remNext;
        dvdReg <= {dvdReg[DIV_W-2:0], fits};
      end
      if (strb.takeInt) lOut <= dvdReg[RATE_W-1:0];
      if (strb.loadFrac) begin
        dvdReg <= {remReg, FRAC_W'(0)};
        remReg <= '0;
      end
      if (strb.takeFrac) alphaOut <= dvdReg[FRAC_W-1:0] + FRAC_W'(!remZero);
      if (strb.calc) begin
        rateOut  <= (opReg == OP_ROUND && !bandHit) ? clampedRate : rateCalc;
        codeOut  <= bandCode;
        rangeErr <= (opReg == OP_SET) && !bandHit;
        if (opReg == OP_SET && bandHit) ctlOut <= ctlNew;
      end
    end
  end

  // R2: remainder stays below the divisor after every step
  a_r2_rem_below_ref: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> remReg < refReg);
  // R7: a failed set leaves the control word as it came in
  a_r7_ctl_kept: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> ctlOut == ctlReg);
  // R8: a rounded rate lies inside the table limits
  a_r8_round_in_limits: assert property (@(posedge clk) disable iff (!rstN)
    (strb.calc && opReg == OP_ROUND) |=> (rateOut >= limLo && rateOut <= limHi));
  // R9: a zero reference never reports a band failure
  a_r9_divzero_no_range: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> !rangeErr);
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_calc_pkg::*;
#(
  parameter int NUM_BANDS = 3,
  parameter logic [NUM_BANDS-1:0][RATE_W-1:0] BAND_MIN =
    {32'd1800000000, 32'd1000000000, 32'd500000000},
  parameter logic [NUM_BANDS-1:0][RATE_W-1:0] BAND_MAX =
    {32'd2000000000, 32'd1500000000, 32'd1000000000},
  parameter logic [NUM_BANDS-1:0][CODE_W-1:0] BAND_CODE =
    {2'd1, 2'd0, 2'd2}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              narrowAlpha,
  input  logic [RATE_W-1:0] refRate,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [RATE_W-1:0] lIn,
  input  logic [WORD_W-1:0] alphaLoIn,
  input  logic [WORD_W-1:0] alphaHiIn,
  input  logic [WORD_W-1:0] ctlIn,
  output logic              busy,
  output logic              done,
  output logic              divZero,
  output logic              rangeErr,
  output logic [CODE_W-1:0] bandCode,
  output logic [RATE_W-1:0] lOut,
  output logic [FRAC_W-1:0] alphaOut,
  output logic [WORD_W-1:0] alphaLoOut,
  output logic [WORD_W-1:0] alphaHiOut,
  output logic [WORD_W-1:0] ctlOut,
  output logic [RES_W-1:0]  rateOut
);
  strobe_t           strb;
  logic              remZero;
  logic [RES_W-1:0]  rateCalc;
  logic              bandHit;
  logic [CODE_W-1:0] lookCode;
  logic [RES_W-1:0]  clampedRate;
  logic [RES_W-1:0]  limLo;
  logic [RES_W-1:0]  limHi;

  pll_calc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isRecalc(op[1]),
    .refZero(refRate == '0), .remZero(remZero),
    .strb(strb), .busy(busy), .done(done)
  );

  pll_calc_band #(
    .NUM_BANDS(NUM_BANDS), .BAND_MIN(BAND_MIN),
    .BAND_MAX(BAND_MAX), .BAND_CODE(BAND_CODE)
  ) u_band (
    .rate(rateCalc), .hit(bandHit), .code(lookCode),
    .clamped(clampedRate), .limLo(limLo), .limHi(limHi)
  );

  pll_calc_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .op(op), .narrowIn(narrowAlpha),
    .refIn(refRate), .reqIn(reqRate), .lIn(lIn),
    .alphaLoIn(alphaLoIn), .alphaHiIn(alphaHiIn), .ctlIn(ctlIn),
    .bandHit(bandHit), .bandCode(lookCode), .clampedRate(clampedRate),
    .limLo(limLo), .limHi(limHi),
    .remZero(remZero), .rateCalc(rateCalc),
    .divZero(divZero), .rangeErr(rangeErr), .codeOut(bandCode),
    .lOut(lOut), .alphaOut(alphaOut), .alphaLoOut(alphaLoOut),
    .alphaHiOut(alphaHiOut), .ctlOut(ctlOut), .rateOut(rateOut)
  );
endmodule

// File: tb/test_pll_rate_calc.sv
module test_pll_rate_calc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic narrowAlpha = 1'b0;
  logic [31:0] refRate = '0, reqRate = '0, lIn = '0;
  logic [31:0] alphaLoIn = '0, alphaHiIn = '0, ctlIn = '0;
  logic busy, done, divZero, rangeErr;
  logic [1:0] bandCode;
  logic [31:0] lOut, alphaOut, alphaLoOut, alphaHiOut, ctlOut;
  logic [63:0] rateOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pll_rate_calc i_pll_rate_calc (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .narrowAlpha(narrowAlpha),
    .refRate(refRate), .reqRate(reqRate), .lIn(lIn),
    .alphaLoIn(alphaLoIn), .alphaHiIn(alphaHiIn), .ctlIn(ctlIn),
    .busy(busy), .done(done), .divZero(divZero), .rangeErr(rangeErr),
    .bandCode(bandCode), .lOut(lOut), .alphaOut(alphaOut),
    .alphaLoOut(alphaLoOut), .alphaHiOut(alphaHiOut),
    .ctlOut(ctlOut), .rateOut(rateOut)
  );

  localparam longint unsigned LIM_LO = 64'd500000000;
  localparam longint unsigned LIM_HI = 64'd2000000000;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] refr;
    logic [31:0] req;
    logic [31:0] ctl;
    logic        narrow;
    logic        hit;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'd19200000, 32'd600000000,  32'h00000000, 1'b0, 1'b1, 2'd2},
    '{2'd0, 32'd19200000, 32'd768000000,  32'h00000000, 1'b0, 1'b1, 2'd2},
    '{2'd0, 32'd19200000, 32'd1000000000, 32'h00000000, 1'b1, 1'b1, 2'd2},
    '{2'd0, 32'd19200000, 32'd1200000000, 32'hFFFFFFFF, 1'b0, 1'b1, 2'd0},
    '{2'd0, 32'd19200000, 32'd1600000000, 32'h12345678, 1'b0, 1'b0, 2'd0},
    '{2'd0, 32'd27000000, 32'd1900000000, 32'h00000000, 1'b0, 1'b1, 2'd1},
    '{2'd1, 32'd19200000, 32'd100000000,  32'h00000000, 1'b0, 1'b0, 2'd0},
    '{2'd1, 32'd19200000, 32'd4000000000, 32'h00000000, 1'b0, 1'b0, 2'd0},
    '{2'd1, 32'd19200000, 32'd1600000000, 32'h00000000, 1'b0, 1'b0, 2'd0},
    '{2'd1, 32'd19200000, 32'd600000000,  32'h00000000, 1'b0, 1'b1, 2'd2},
    '{2'd0, 32'd7,        32'd1000000003, 32'h00000000, 1'b0, 1'b1, 2'd0}
  };

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned rateOf(input longint unsigned r,
      input longint unsigned l, input longint unsigned a);
    return r * l + ((r * a) >> 32);
  endfunction

  task automatic waitDone();
    int w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    if (!done) check(1'b0, "R10 done never seen", 0, 1);
  endtask

  task automatic runOp(input logic [1:0] o, input logic [31:0] r, q, l, lo, hi, c,
                       input logic n);
    @(negedge clk);
    op = o; refRate = r; reqRate = q; lIn = l;
    alphaLoIn = lo; alphaHiIn = hi; ctlIn = c; narrowAlpha = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint unsigned eL, eA, eR, rm, sc, eLo, eHi, eCtl;

    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !done, "R11 busy/done after reset", {busy, done}, 0);
    check(!divZero && !rangeErr, "R11 error flags after reset", {divZero, rangeErr}, 0);
    check(lOut == 0 && alphaOut == 0, "R11 L/alpha after reset", lOut, 0);
    check(rateOut == 0, "R11 rate after reset", rateOut, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].op, VECS[i].refr, VECS[i].req, 0, 0, 0, VECS[i].ctl, VECS[i].narrow);
      eL = VECS[i].req / VECS[i].refr;
      rm = VECS[i].req % VECS[i].refr;
      if (rm == 0) eA = 0;
      else begin
        sc = rm << 32;
        eA = sc / VECS[i].refr + ((sc % VECS[i].refr) != 0 ? 1 : 0);
      end
      eR = rateOf(VECS[i].refr, eL, eA);
      if (VECS[i].op == 2'd1 && !VECS[i].hit)
        eR = (eR < LIM_LO) ? LIM_LO : (eR > LIM_HI) ? LIM_HI : eR;
      if (VECS[i].narrow) begin
        eLo = eA & 64'hFFFF; eHi = 0;
      end else begin
        eLo = (eA << 8) & 64'hFFFFFFFF; eHi = eA >> 24;
      end
      eCtl = VECS[i].ctl;
      if (VECS[i].op == 2'd0 && VECS[i].hit)
        eCtl = (eCtl & ~64'h00300000) | (64'(VECS[i].code) << 20) | 64'h01000000;
      check(lOut == eL[31:0], $sformatf("R1 L vec%0d", i), lOut, eL);
      check(alphaOut == eA[31:0], $sformatf("R2 alpha vec%0d", i), alphaOut, eA);
      check(rateOut == eR, $sformatf("R3/R8 rate vec%0d", i), rateOut, eR);
      check(bandCode == VECS[i].code, $sformatf("R6 band vec%0d", i), bandCode, VECS[i].code);
      check(rangeErr == (VECS[i].op == 2'd0 && !VECS[i].hit),
            $sformatf("R7 rangeErr vec%0d", i), rangeErr, !VECS[i].hit);
      check(ctlOut == eCtl[31:0], $sformatf("R6/R7 ctl vec%0d", i), ctlOut, eCtl);
      check(alphaLoOut == eLo[31:0] && alphaHiOut == eHi[31:0],
            $sformatf("R4 packing vec%0d", i), {alphaHiOut, alphaLoOut}, (eHi << 32) | eLo);
      check(!divZero, $sformatf("R9 no divZero vec%0d", i), divZero, 0);
    end

    // R1: exact multiple gives the requested rate back
    runOp(2'd0, 32'd19200000, 32'd768000000, 0, 0, 0, 0, 1'b0);
    check(rateOut == 64'd768000000 && alphaOut == 0, "R1 exact multiple", rateOut, 768000000);

    // R5: wide readback with fraction enabled
    runOp(2'd2, 32'd19200000, 0, 32'd31, 32'h0, 32'h40, 32'h01000000, 1'b0);
    check(alphaOut == 32'h40000000, "R5 wide readback alpha", alphaOut, 32'h40000000);
    check(rateOut == 64'd600000000, "R5 wide readback rate", rateOut, 600000000);
    check(!rangeErr && ctlOut == 32'h01000000, "R5 readback leaves ctl", ctlOut, 32'h01000000);

    // R5: fraction disabled by bit 24 clear
    runOp(2'd2, 32'd19200000, 0, 32'd31, 32'h0, 32'h40, 32'h0, 1'b0);
    check(alphaOut == 0 && rateOut == 64'd595200000, "R5 fraction disabled", rateOut, 595200000);

    // R5: narrow readback with op 3
    runOp(2'd3, 32'd19200000, 0, 32'd31, 32'hABC18000, 32'hFF, 32'h01000000, 1'b1);
    eR = rateOf(19200000, 31, 64'h8000);
    check(alphaOut == 32'h8000, "R5 narrow readback alpha", alphaOut, 32'h8000);
    check(rateOut == eR, "R5 narrow readback rate", rateOut, eR);

    // R9: zero reference
    runOp(2'd0, 32'd0, 32'd600000000, 0, 0, 0, 32'h5, 1'b0);
    check(divZero && !rangeErr, "R9 divZero raised", divZero, 1);
    runOp(2'd1, 32'd19200000, 32'd600000000, 0, 0, 0, 0, 1'b0);
    check(!divZero, "R9 divZero cleared", divZero, 0);

    // R10: single-cycle done, busy while running, start while busy ignored
    @(negedge clk);
    check(!done, "R10 done one cycle", done, 0);
    op = 2'd0; refRate = 32'd19200000; reqRate = 32'd600000000; ctlIn = 0;
    narrowAlpha = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10 busy after start", busy, 1);
    repeat (20) @(negedge clk);
    reqRate = 32'd1200000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check(lOut == 32'd31 && alphaOut == 32'h40000000, "R10 start while busy ignored",
          lOut, 31);
    check(!busy, "R10 not busy at done", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule